// File: doc/BRIEF.md
# Gated Sixteen-Bit Timer/Counter

This block is a 16-bit up-counter built for a peripheral set. It takes its count pulses from one of three sources: the system clock divided by four, the system clock itself, or an external clock pin. A power-of-two prescaler sits in front of the counter. On the external path, the pin can go through a two-flop synchroniser or through a single capture flop for lower latency. When the count wraps past its top value, a sticky overflow flag is set.

A gate unit can restrict counting to the intervals when a gate signal is active. It takes its gate from one of four inputs: a gate pin, a period-match pulse from a companion timer, or one of two comparator outputs. It can invert that signal, and it can replace the level with a flip-flop that toggles on each active edge. In single-pulse acquisition mode, software arms one measurement with a go strobe. The busy bit then drops by itself when the gate pulse ends. A gate-event flag records each completed gate interval.

Software reads the count as two bytes and writes each byte through a shared byte bus. Control fields are plain inputs that a register elsewhere holds.

Top module: `gated_timer16`

## Requirements
- R1: After reset the count is 0x0000, and the overflow flag, the gate-event flag and the busy bit are all 0.
- R2: clk_sel 00 gives one count pulse every 4th clock, 01 gives one on every clock, and 11 gives none. After enable, the first divide-by-4 pulse arrives on the 4th clock.
- R3: presc_sel p divides the count pulses by 2^p (1, 2, 4 or 8). After N enabled clocks from a cleared state, the count is N/(4·2^p) in mode 00 and N/2^p in mode 01, with integer division.
- R4: With clk_sel 10, each rising edge of ext_clk adds one count, but only after at least one falling edge has been seen since the timer was enabled. ext_sync=1 uses a two-flop synchroniser and ext_sync=0 a single flop; the count total is the same either way.
- R5: While tmr_on is 0 and no write is made, the count holds. wr_lo or wr_hi loads the byte on wr_data at the next clock and takes the place of any increment on that clock. Either write also clears the prescaler's internal count.
- R6: When the count wraps from 0xFFFF to 0x0000, ovf_flag is set. It stays set until ovf_clr is pulsed.
- R7: With gate_en=1, counting happens only while the gate is active. gate_sel selects the gate: 00 is gate_pin (through a two-flop synchroniser), 01 is peer_match, 10 is cmp1 and 11 is cmp2. gate_inv=1 makes the gate active when that input is low.
- R8: With gate_toggle=1, a flip-flop flips on each rising edge of the active gate signal and acts as the gate. Two edges D clocks apart therefore allow D counts.
- R9: With gate_single=1, a go_set pulse sets go_busy. The count then runs for exactly one gate pulse, from its rising edge to its falling edge. go_busy then clears and gevt_flag is set, and later gate pulses add no counts.
- R10: Outside single-pulse mode, gevt_flag is set at the end of each active gate interval. gevt_clr clears it.
- R11: gate_level shows the gate as the counter uses it, after polarity and toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_on | input | 1 | Timer enable |
| clk_sel | input | 2 | Count source select |
| presc_sel | input | 2 | Prescaler ratio select |
| ext_sync | input | 1 | 1: two-flop sync on external clock |
| gate_en | input | 1 | Enable gate control |
| gate_inv | input | 1 | Gate active low when 1 |
| gate_toggle | input | 1 | Gate toggle mode |
| gate_single | input | 1 | Single-pulse acquisition mode |
| gate_sel | input | 2 | Gate source select |
| go_set | input | 1 | Arm one acquisition |
| wr_lo | input | 1 | Write low count byte |
| wr_hi | input | 1 | Write high count byte |
| wr_data | input | 8 | Byte write data |
| ovf_clr | input | 1 | Clear overflow flag |
| gevt_clr | input | 1 | Clear gate-event flag |
| ext_clk | input | 1 | External count clock |
| gate_pin | input | 1 | External gate pin |
| peer_match | input | 1 | Companion timer period-match pulse |
| cmp1 | input | 1 | Comparator 1 output |
| cmp2 | input | 1 | Comparator 2 output |
| count_lo | output | 8 | Count low byte |
| count_hi | output | 8 | Count high byte |
| ovf_flag | output | 1 | Sticky overflow flag |
| gevt_flag | output | 1 | Sticky gate-event flag |
| go_busy | output | 1 | Acquisition armed or running |
| gate_level | output | 1 | Effective gate level |

## Verification
The bench uses the default parameters: 8-bit bytes, a 2-bit prescaler select and two synchroniser stages. With these, both internal sources can be swept against every prescaler ratio and several run lengths, and each expected count is a single integer division. Preloading values near 0xFFFF through the byte writes brings the overflow wrap within a few clocks. Every gate source, polarity, toggle and single-pulse case is driven with pulse lengths chosen so that the expected count equals the length of the gate interval.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int PS_W   = 2;
    localparam int PSC_W  = (1 << PS_W) - 1;

    typedef enum logic [1:0] {
        SRC_INSTR = 2'b00,
        SRC_SYS   = 2'b01,
        SRC_EXT   = 2'b10,
        SRC_NONE  = 2'b11
    } clk_src_e;

    typedef enum logic [1:0] {
        GSRC_PIN  = 2'b00,
        GSRC_PEER = 2'b01,
        GSRC_CMPA = 2'b10,
        GSRC_CMPB = 2'b11
    } gate_src_e;

    typedef struct packed {
        logic            run;
        clk_src_e        src;
        logic [PS_W-1:0] presc;
        logic            ext_sync;
    } cnt_cfg_t;

    typedef struct packed {
        logic      enable;
        logic      invert;
        logic      toggle;
        logic      single;
        gate_src_e sel;
    } gate_cfg_t;

    function automatic logic [PSC_W-1:0] presc_top(input logic [PS_W-1:0] ps);
        return PSC_W'((1 << ps) - 1);
    endfunction
endpackage

// File: rtl/gtmr_tick_src.sv
module gtmr_tick_src
    import gtmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DIV_W       = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  cnt_cfg_t cfg,
    input  logic     ext_clk,
    output logic     tick
);
    logic [SYNC_STAGES-1:0] ext_sh;
    logic                   ext_lvl, ext_prev, ext_rise, ext_fall;
    logic                   armed;
    logic [DIV_W-1:0]       div_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_sh   <= '0;
            ext_prev <= 1'b0;
        end else begin
            ext_sh   <= {ext_sh[SYNC_STAGES-2:0], ext_clk};
            ext_prev <= ext_lvl;
        end
    end

    assign ext_lvl  = cfg.ext_sync ? ext_sh[SYNC_STAGES-1] : ext_sh[0];
    assign ext_rise = ext_lvl & ~ext_prev;
    assign ext_fall = ~ext_lvl & ext_prev;

    // counting on the external pin waits for a first falling edge
    always_ff @(posedge clk) begin
        if (rst || !cfg.run || cfg.src != SRC_EXT) armed <= 1'b0;
        else if (ext_fall)                         armed <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || !cfg.run) div_q <= '0;
        else                 div_q <= div_q + 1'b1;
    end

    always_comb begin
        case (cfg.src)
            SRC_INSTR: tick = &div_q;
            SRC_SYS:   tick = 1'b1;
            SRC_EXT:   tick = armed & ext_rise;
            default:   tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/gtmr_gate.sv
module gtmr_gate
    import gtmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    input  gate_cfg_t cfg,
    input  logic      gate_pin,
    input  logic      peer_match,
    input  logic      cmp1,
    input  logic      cmp2,
    input  logic      go_set,
    output logic      gate_ok,
    output logic      gate_level,
    output logic      go_busy,
    output logic      gate_evt
);
    logic [SYNC_STAGES-1:0] pin_sh;
    logic raw, act, act_d, act_rise;
    logic tog_q, eff, eff_d, eff_rise, eff_fall;
    logic go_q, acq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_sh <= '0;
            act_d  <= 1'b0;
            eff_d  <= 1'b0;
        end else begin
            pin_sh <= {pin_sh[SYNC_STAGES-2:0], gate_pin};
            act_d  <= act;
            eff_d  <= eff;
        end
    end

    always_comb begin
        case (cfg.sel)
            GSRC_PIN:  raw = pin_sh[SYNC_STAGES-1];
            GSRC_PEER: raw = peer_match;
            GSRC_CMPA: raw = cmp1;
            default:   raw = cmp2;
        endcase
    end

    assign act      = raw ^ cfg.invert;
    assign act_rise = act & ~act_d;

    always_ff @(posedge clk) begin
        if (rst || !run || !cfg.toggle) tog_q <= 1'b0;
        else if (act_rise)              tog_q <= ~tog_q;
    end

    assign eff      = cfg.toggle ? tog_q : act;
    assign eff_rise = eff & ~eff_d;
    assign eff_fall = ~eff & eff_d;

    always_ff @(posedge clk) begin
        if (rst || !cfg.single || !cfg.enable) begin
            go_q  <= 1'b0;
            acq_q <= 1'b0;
        end else begin
            if (go_set)                 go_q <= 1'b1;
            else if (acq_q && eff_fall) go_q <= 1'b0;
            if (acq_q && eff_fall)      acq_q <= 1'b0;
            else if (go_q && eff_rise)  acq_q <= 1'b1;
        end
    end

    assign gate_ok    = cfg.single ? (go_q && eff && (acq_q || eff_rise)) : eff;
    assign gate_evt   = cfg.enable && (cfg.single ? (acq_q && eff_fall) : eff_fall);
    assign gate_level = eff;
    assign go_busy    = go_q;
endmodule

// File: rtl/gtmr_core.sv
module gtmr_core
    import gtmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              tick,
    input  logic              cnt_en,
    input  logic [PS_W-1:0]   presc,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              ovf_clr,
    input  logic              evt,
    input  logic              evt_clr,
    output logic [CNT_W-1:0]  count,
    output logic              ovf,
    output logic              evt_flag
);
    logic [PSC_W-1:0] psc_q;
    logic             gtick, inc, wr_any, at_top;

    assign wr_any = wr_lo | wr_hi;
    assign gtick  = run & tick & cnt_en;
    assign at_top = (psc_q == presc_top(presc));
    assign inc    = gtick & at_top;

    always_ff @(posedge clk) begin
        if (rst || !run || wr_any) psc_q <= '0;
        else if (gtick)            psc_q <= at_top ? '0 : psc_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (wr_any) begin
            if (wr_lo) count[BYTE_W-1:0]     <= wr_data;
            if (wr_hi) count[CNT_W-1:BYTE_W] <= wr_data;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                             ovf <= 1'b0;
        else if (inc && !wr_any && &count)   ovf <= 1'b1;
        else if (ovf_clr)                    ovf <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)          evt_flag <= 1'b0;
        else if (evt)     evt_flag <= 1'b1;
        else if (evt_clr) evt_flag <= 1'b0;
    end
endmodule

// File: rtl/gated_timer16.sv
module gated_timer16
    import gtmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tmr_on,
    input  logic [1:0]        clk_sel,
    input  logic [PS_W-1:0]   presc_sel,
    input  logic              ext_sync,
    input  logic              gate_en,
    input  logic              gate_inv,
    input  logic              gate_toggle,
    input  logic              gate_single,
    input  logic [1:0]        gate_sel,
    input  logic              go_set,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              ovf_clr,
    input  logic              gevt_clr,
    input  logic              ext_clk,
    input  logic              gate_pin,
    input  logic              peer_match,
    input  logic              cmp1,
    input  logic              cmp2,
    output logic [BYTE_W-1:0] count_lo,
    output logic [BYTE_W-1:0] count_hi,
    output logic              ovf_flag,
    output logic              gevt_flag,
    output logic              go_busy,
    output logic              gate_level
);
    cnt_cfg_t         ccfg;
    gate_cfg_t        gcfg;
    logic             tick, gate_ok, gate_evt;
    logic [CNT_W-1:0] count;

    assign ccfg = '{run: tmr_on, src: clk_src_e'(clk_sel), presc: presc_sel, ext_sync: ext_sync};
    assign gcfg = '{enable: gate_en, invert: gate_inv, toggle: gate_toggle,
                    single: gate_single, sel: gate_src_e'(gate_sel)};

    gtmr_tick_src #(.SYNC_STAGES(SYNC_STAGES), .DIV_W(2)) u_src (
        .clk(clk), .rst(rst), .cfg(ccfg), .ext_clk(ext_clk), .tick(tick)
    );

    gtmr_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
        .clk(clk), .rst(rst), .run(tmr_on), .cfg(gcfg),
        .gate_pin(gate_pin), .peer_match(peer_match), .cmp1(cmp1), .cmp2(cmp2),
        .go_set(go_set), .gate_ok(gate_ok), .gate_level(gate_level),
        .go_busy(go_busy), .gate_evt(gate_evt)
    );

    gtmr_core u_core (
        .clk(clk), .rst(rst), .run(tmr_on), .tick(tick),
        .cnt_en(!gate_en || gate_ok), .presc(presc_sel),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data), .ovf_clr(ovf_clr),
        .evt(gate_evt), .evt_clr(gevt_clr),
        .count(count), .ovf(ovf_flag), .evt_flag(gevt_flag)
    );

    assign count_lo = count[BYTE_W-1:0];
    assign count_hi = count[CNT_W-1:BYTE_W];
endmodule

// File: rtl/gated_timer16_chk.sv
module gated_timer16_chk (
    input logic       clk,
    input logic       rst,
    input logic       tmr_on,
    input logic [1:0] clk_sel,
    input logic       gate_en,
    input logic       gate_single,
    input logic       wr_lo,
    input logic       wr_hi,
    input logic       ovf_clr,
    input logic [7:0] count_lo,
    input logic [7:0] count_hi,
    input logic       ovf_flag,
    input logic       gevt_flag,
    input logic       go_busy,
    input logic       gate_level
);
    logic [15:0] cnt;
    logic        nowr;
    assign cnt  = {count_hi, count_lo};
    assign nowr = !wr_lo && !wr_hi;

    assert_hold_off_R5: assert property (@(posedge clk) disable iff (rst)
        (!tmr_on && nowr) |=> cnt == $past(cnt));

    assert_single_step_R2: assert property (@(posedge clk) disable iff (rst)
        nowr |=> (cnt == $past(cnt) || cnt == 16'($past(cnt) + 16'd1)));

    assert_no_source_R2: assert property (@(posedge clk) disable iff (rst)
        (clk_sel == 2'b11 && nowr) |=> $stable(cnt));

    assert_ovf_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_flag) |-> ($past(cnt) == 16'hFFFF && cnt == 16'h0000));

    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    assert_gate_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        (gate_en && !gate_level && nowr) |=> $stable(cnt));

    assert_done_flag_R9: assert property (@(posedge clk) disable iff (rst)
        ($fell(go_busy) && $past(gate_en && gate_single)) |-> gevt_flag);

    assert_go_mode_R9: assert property (@(posedge clk) disable iff (rst)
        !gate_single |=> !go_busy);
endmodule

bind gated_timer16 gated_timer16_chk u_chk (
    .clk(clk), .rst(rst), .tmr_on(tmr_on), .clk_sel(clk_sel),
    .gate_en(gate_en), .gate_single(gate_single),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .ovf_clr(ovf_clr),
    .count_lo(count_lo), .count_hi(count_hi), .ovf_flag(ovf_flag),
    .gevt_flag(gevt_flag), .go_busy(go_busy), .gate_level(gate_level)
);

// File: tb/sim_gated_timer16.sv
module sim_gated_timer16;
    logic       clk = 1'b0, rst = 1'b1;
    logic       tmr_on = 0, ext_sync = 0, gate_en = 0, gate_inv = 0;
    logic       gate_toggle = 0, gate_single = 0, go_set = 0;
    logic [1:0] clk_sel = 0, presc_sel = 0, gate_sel = 0;
    logic       wr_lo = 0, wr_hi = 0, ovf_clr = 0, gevt_clr = 0;
    logic [7:0] wr_data = 0;
    logic       ext_clk = 0, gate_pin = 0, peer_match = 0, cmp1 = 0, cmp2 = 0;
    logic [7:0] count_lo, count_hi;
    logic       ovf_flag, gevt_flag, go_busy, gate_level;
    int         n_run = 0, n_fail = 0;
    bit         done = 0;

    always #10 clk = ~clk;

    gated_timer16 u0 (.*);

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load(input logic [15:0] v);
        wr_lo = 1; wr_data = v[7:0];  @(negedge clk);
        wr_lo = 0; wr_hi = 1; wr_data = v[15:8]; @(negedge clk);
        wr_hi = 0;
    endtask

    function automatic logic [15:0] cnt();
        return {count_hi, count_lo};
    endfunction

    task automatic run_for(input int n);
        tmr_on = 1; step(n); tmr_on = 0;
    endtask

    task automatic ext_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            ext_clk = 1; step(3); ext_clk = 0; step(3);
        end
    endtask

    initial begin
        step(3); rst = 0; @(negedge clk);
        // R1 reset state
        chk("R1 count", cnt(), 16'h0);
        chk("R1 flags", {13'h0, ovf_flag, gevt_flag, go_busy}, 16'h0);

        // R2 / R3 sweep of internal sources and prescaler ratios
        foreach (clk_sel[i]) ;
        for (int cs = 0; cs < 2; cs++) begin
            for (int ps = 0; ps < 4; ps++) begin
                for (int k = 0; k < 3; k++) begin
                    int n;
                    int e;
                    n = (k == 0) ? 5 : (k == 1) ? 13 : 37;
                    load(16'h0);
                    clk_sel = 2'(cs); presc_sel = 2'(ps);
                    run_for(n);
                    e = (cs == 0) ? n / (4 << ps) : n >> ps;
                    chk($sformatf("R2 R3 cs=%0d ps=%0d n=%0d", cs, ps, n), cnt(), 16'(e));
                end
            end
        end

        // R2 no source
        load(16'h0); clk_sel = 2'b11; presc_sel = 0;
        run_for(20);
        chk("R2 source 11 idle", cnt(), 16'h0);

        // R5 hold while disabled
        clk_sel = 2'b01; load(16'h00AA); step(10);
        chk("R5 hold while off", cnt(), 16'h00AA);

        // R5 write while running
        load(16'h0); tmr_on = 1; step(4);
        load(16'h1234); step(5);
        tmr_on = 0;
        chk("R5 write while running", cnt(), 16'h1239);

        // R5 write clears prescaler
        presc_sel = 2'd3; load(16'h0);
        tmr_on = 1; step(5);
        chk("R5 divide-by-8 before write", cnt(), 16'h0);
        load(16'h0100); step(7);
        chk("R5 prescaler cleared (7)", cnt(), 16'h0100);
        step(1);
        chk("R5 prescaler cleared (8)", cnt(), 16'h0101);
        tmr_on = 0; presc_sel = 0;

        // R6 overflow
        load(16'hFFFE); tmr_on = 1; step(1);
        chk("R6 at top", {cnt()}, 16'hFFFF);
        chk("R6 no flag yet", {15'h0, ovf_flag}, 16'h0);
        step(1);
        chk("R6 wrap", cnt(), 16'h0);
        chk("R6 flag set", {15'h0, ovf_flag}, 16'h1);
        step(3); tmr_on = 0;
        chk("R6 flag sticky", {15'h0, ovf_flag}, 16'h1);
        ovf_clr = 1; @(negedge clk); ovf_clr = 0;
        chk("R6 flag cleared", {15'h0, ovf_flag}, 16'h0);

        // R4 external clock, both sync settings
        clk_sel = 2'b10;
        for (int s = 1; s >= 0; s--) begin
            ext_sync = s[0]; ext_clk = 0; load(16'h0); step(4);
            tmr_on = 1; step(2);
            ext_pulses(5); step(4); tmr_on = 0;
            chk($sformatf("R4 first rise ignored sync=%0d", s), cnt(), 16'd4);
        end
        ext_sync = 1; ext_clk = 1; load(16'h0); step(4);
        tmr_on = 1; step(2); ext_clk = 0; step(3);
        ext_pulses(3); step(4); tmr_on = 0;
        chk("R4 start high", cnt(), 16'd3);

        // R7 gate pin, active high
        clk_sel = 2'b01; gate_en = 1; gate_sel = 2'b00; gate_pin = 0;
        load(16'h0); step(4); gevt_clr = 1; @(negedge clk); gevt_clr = 0;
        tmr_on = 1; step(5);
        gate_pin = 1; step(7); gate_pin = 0; step(5); tmr_on = 0;
        chk("R7 pin gate", cnt(), 16'd7);
        chk("R10 event after gate end", {15'h0, gevt_flag}, 16'h1);
        gevt_clr = 1; @(negedge clk); gevt_clr = 0;
        chk("R10 event cleared", {15'h0, gevt_flag}, 16'h0);

        // R7 inverted polarity
        gate_pin = 1; gate_inv = 1; load(16'h0); step(4);
        tmr_on = 1; step(5);
        gate_pin = 0; step(6); gate_pin = 1; step(5); tmr_on = 0;
        chk("R7 inverted pin gate", cnt(), 16'd6);
        gate_inv = 0; gate_pin = 0;

        // R7 peer match pulses
        gate_sel = 2'b01; load(16'h0); tmr_on = 1;
        for (int i = 0; i < 3; i++) begin
            peer_match = 1; step(1); peer_match = 0; step(4);
        end
        tmr_on = 0;
        chk("R7 peer match", cnt(), 16'd3);

        // R7 / R11 comparator sources
        gate_sel = 2'b10; load(16'h0); tmr_on = 1;
        cmp1 = 1; cmp2 = 1; step(4); cmp2 = 0;
        chk("R11 level high", {15'h0, gate_level}, 16'h1);
        step(5); cmp1 = 0; step(3); tmr_on = 0;
        chk("R11 level low", {15'h0, gate_level}, 16'h0);
        chk("R7 cmp1 gate", cnt(), 16'd9);
        gate_sel = 2'b11; load(16'h0); tmr_on = 1;
        cmp2 = 1; cmp1 = 1; step(4); cmp2 = 0; step(3); cmp1 = 0; step(2); tmr_on = 0;
        chk("R7 cmp2 gate", cnt(), 16'd4);

        // R8 toggle mode
        gate_sel = 2'b10; gate_toggle = 1; load(16'h0); tmr_on = 1; step(2);
        cmp1 = 1; step(1); cmp1 = 0; step(4);
        chk("R11 toggle level", {15'h0, gate_level}, 16'h1);
        step(5);
        cmp1 = 1; step(1); cmp1 = 0; step(5); tmr_on = 0;
        chk("R8 toggle window", cnt(), 16'd10);
        gate_toggle = 0;

        // R9 single pulse acquisition
        gate_single = 1; load(16'h0); gevt_clr = 1; @(negedge clk); gevt_clr = 0;
        tmr_on = 1; step(2);
        go_set = 1; step(1); go_set = 0;
        chk("R9 armed", {15'h0, go_busy}, 16'h1);
        step(3);
        cmp1 = 1; step(6); cmp1 = 0; step(2);
        chk("R9 one pulse counted", cnt(), 16'd6);
        chk("R9 done", {14'h0, go_busy, gevt_flag}, 16'h1);
        cmp1 = 1; step(5); cmp1 = 0; step(2); tmr_on = 0;
        chk("R9 later pulse ignored", cnt(), 16'd6);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule